// File: doc/BRIEF.md
# Keyed Configuration Register Port

This block is the configuration front end of a multi-function peripheral controller. The host sees it as two byte-wide ports: an index port and a data port. Configuration is locked after reset. A host unlocks it by writing a two-byte key to the index port. From then on it programs a register by writing the register number to the index port and the value to the data port. One exit byte written to the index port locks the block again.

Registers are banked. A global device-select register picks one of several logical devices: floppy, parallel port, two serial ports, real-time clock, keyboard/mouse and general-purpose I/O. Per-device register numbers then address that device's bank. Each bank holds an activate bit, a 16-bit base I/O address, two interrupt numbers, a DMA channel and a small set of mode bytes. Every bank drives its values onto flat configuration outputs, which the peripheral blocks elsewhere in the chip consume. A global soft-reset register returns every bank to its defaults.

The read value of the data port is always present on `rdata`. It reflects the register currently addressed by the index.

Top module: `cfgp_port`

## Requirements
- R1: After reset the block is locked. Writing 0x51 and then 0x23 to the index port (`port_sel`=0) enters configuration mode.
- R2: While locked, data-port writes (`port_sel`=1) change nothing and `rdata` reads 0xFF.
- R3: While locked, an index write that is not the expected next key byte sends the key sequence back to its start. That wrong byte does not count as a first key byte, so 0x51,0x51,0x23 does not unlock.
- R4: While in configuration mode, writing 0xBB to the index port locks the block again. The stored index and the device select keep their values.
- R5: Register 0x07 is the device select and reads back the full byte written. Device numbers 0 to 8 each select a bank. A larger number selects no bank: bank writes are then ignored and bank registers read 0xFF.
- R6: Register 0x30 bit 0 is the selected device's activate bit and drives `dev_en[d]`. The register reads back as {7'b0, bit}.
- R7: Register 0x60 is the high byte and 0x61 the low byte of the base address, driven as `dev_base[d*16 +: 16]`.
- R8: Register 0x70 drives `dev_irq_a[d*8 +: 8]`, 0x72 drives `dev_irq_b[d*8 +: 8]`, and 0x74 drives `dev_dma[d*8 +: 8]`.
- R9: Registers 0xF0 to 0xF4 are mode bytes 0 to 4, driven as `dev_mode[(d*5+k)*8 +: 8]`.
- R10: A data write changes only the bank of the currently selected device.
- R11: A data write to register 0x02 with bit 0 set clears every bank to zero on that clock edge. Register 0x02 always reads 0x00. Writing it with bit 0 clear has no effect. Device select and lock state are kept.
- R12: In configuration mode, any register number not listed above reads 0xFF and ignores writes.
- R13: After reset every configuration output is zero and the device select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per byte |
| port_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Data-port read value for the current index |
| dev_en | output | NDEV | Activate bit per device |
| dev_base | output | NDEV*16 | Base I/O address per device |
| dev_irq_a | output | NDEV*8 | Primary interrupt number per device |
| dev_irq_b | output | NDEV*8 | Secondary interrupt number per device |
| dev_dma | output | NDEV*8 | DMA channel per device |
| dev_mode | output | NDEV*NMODE*8 | Mode bytes per device |

## Verification
The unlock logic is tried with the correct key, a repeated first key byte, and a stray byte between the two key bytes. Only the correct key opens the port, which shows that a mismatch restarts the sequence rather than resynchronising. Register programming is tried on two different devices and on an out-of-range select, which separates correct bank steering from writes that leak into other banks. Reads of unmapped numbers and of the edge mode byte check the decode boundaries. Soft reset is applied with bit 0 clear and then set, and the exit byte is followed by a data write that must not land. Together these show that each gating condition is honoured separately.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'h51;
  localparam logic [7:0] KEY_SECOND = 8'h23;
  localparam logic [7:0] KEY_EXIT   = 8'hBB;

  localparam logic [7:0] IX_SRST  = 8'h02;
  localparam logic [7:0] IX_DSEL  = 8'h07;
  localparam logic [7:0] IX_ACT   = 8'h30;
  localparam logic [7:0] IX_BASEH = 8'h60;
  localparam logic [7:0] IX_BASEL = 8'h61;
  localparam logic [7:0] IX_IRQA  = 8'h70;
  localparam logic [7:0] IX_IRQB  = 8'h72;
  localparam logic [7:0] IX_DMA   = 8'h74;
  localparam logic [7:0] IX_MODE0 = 8'hF0;

  localparam logic [7:0] RD_NONE  = 8'hFF;

  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lk_state_e;
endpackage

// File: rtl/cfgp_keylock.sv
module cfgp_keylock
  import cfgp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open_o
);
  lk_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr) begin
      case (st_q)
        LK_SHUT: st_d = (wdata == KEY_FIRST)  ? LK_HALF : LK_SHUT;
        LK_HALF: st_d = (wdata == KEY_SECOND) ? LK_OPEN : LK_SHUT;
        LK_OPEN: st_d = (wdata == KEY_EXIT)   ? LK_SHUT : LK_OPEN;
        default: st_d = LK_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LK_SHUT;
    else        st_q <= st_d;
  end

  assign open_o = (st_q == LK_OPEN);
endmodule

// File: rtl/cfgp_bank.sv
module cfgp_bank
  import cfgp_pkg::*;
#(
  parameter int NMODE = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wr,
  input  logic [7:0]         idx,
  input  logic [7:0]         wdata,
  output logic               en_o,
  output logic [15:0]        base_o,
  output logic [7:0]         irqa_o,
  output logic [7:0]         irqb_o,
  output logic [7:0]         dma_o,
  output logic [NMODE*8-1:0] mode_o,
  output logic [7:0]         rd_o
);
  logic       act_q, act_d;
  logic [7:0] bh_q, bh_d, bl_q, bl_d;
  logic [7:0] ia_q, ia_d, ib_q, ib_d, dm_q, dm_d;
  logic [7:0] md_q [NMODE];
  logic [7:0] md_d [NMODE];

  always_comb begin
    act_d = act_q; bh_d = bh_q; bl_d = bl_q;
    ia_d = ia_q; ib_d = ib_q; dm_d = dm_q;
    md_d = md_q;
    if (clr) begin
      act_d = 1'b0; bh_d = '0; bl_d = '0;
      ia_d = '0; ib_d = '0; dm_d = '0;
      for (int k = 0; k < NMODE; k++) md_d[k] = '0;
    end else if (wr) begin
      case (idx)
        IX_ACT:   act_d = wdata[0];
        IX_BASEH: bh_d  = wdata;
        IX_BASEL: bl_d  = wdata;
        IX_IRQA:  ia_d  = wdata;
        IX_IRQB:  ib_d  = wdata;
        IX_DMA:   dm_d  = wdata;
        default: begin
          for (int k = 0; k < NMODE; k++)
            if (idx == IX_MODE0 + 8'(k)) md_d[k] = wdata;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; bh_q <= '0; bl_q <= '0;
      ia_q <= '0; ib_q <= '0; dm_q <= '0;
      md_q <= '{default: '0};
    end else begin
      act_q <= act_d; bh_q <= bh_d; bl_q <= bl_d;
      ia_q <= ia_d; ib_q <= ib_d; dm_q <= dm_d;
      md_q <= md_d;
    end
  end

  always_comb begin
    case (idx)
      IX_ACT:   rd_o = {7'b0, act_q};
      IX_BASEH: rd_o = bh_q;
      IX_BASEL: rd_o = bl_q;
      IX_IRQA:  rd_o = ia_q;
      IX_IRQB:  rd_o = ib_q;
      IX_DMA:   rd_o = dm_q;
      default: begin
        rd_o = RD_NONE;
        for (int k = 0; k < NMODE; k++)
          if (idx == IX_MODE0 + 8'(k)) rd_o = md_q[k];
      end
    endcase
  end

  assign en_o   = act_q;
  assign base_o = {bh_q, bl_q};
  assign irqa_o = ia_q;
  assign irqb_o = ib_q;
  assign dma_o  = dm_q;

  for (genvar k = 0; k < NMODE; k++) begin : g_mode
    assign mode_o[k*8 +: 8] = md_q[k];
  end
endmodule

// File: rtl/cfgp_port.sv
module cfgp_port
  import cfgp_pkg::*;
#(
  parameter int NDEV  = 9,
  parameter int NMODE = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    port_sel,
  input  logic [7:0]              wdata,
  output logic [7:0]              rdata,
  output logic [NDEV-1:0]         dev_en,
  output logic [NDEV*16-1:0]      dev_base,
  output logic [NDEV*8-1:0]       dev_irq_a,
  output logic [NDEV*8-1:0]       dev_irq_b,
  output logic [NDEV*8-1:0]       dev_dma,
  output logic [NDEV*NMODE*8-1:0] dev_mode
);
  localparam int MW = NMODE * 8;

  logic       cfg_open;
  logic       idx_wr, dat_wr, srst;
  logic [7:0] idx_q, idx_d;
  logic [7:0] dsel_q, dsel_d;
  logic [7:0] bank_rd [NDEV];
  logic [7:0] sel_rd;

  assign idx_wr = wr_en & ~port_sel;
  assign dat_wr = wr_en & port_sel & cfg_open;
  assign srst   = dat_wr & (idx_q == IX_SRST) & wdata[0];

  cfgp_keylock u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx_wr (idx_wr),
    .wdata  (wdata),
    .open_o (cfg_open)
  );

  always_comb begin
    idx_d  = idx_q;
    dsel_d = dsel_q;
    if (cfg_open && idx_wr && (wdata != KEY_EXIT)) idx_d = wdata;
    if (dat_wr && (idx_q == IX_DSEL))              dsel_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      dsel_q <= '0;
    end else begin
      idx_q  <= idx_d;
      dsel_q <= dsel_d;
    end
  end

  for (genvar i = 0; i < NDEV; i++) begin : g_bank
    cfgp_bank #(.NMODE(NMODE)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (srst),
      .wr     (dat_wr && (dsel_q == 8'(i))),
      .idx    (idx_q),
      .wdata  (wdata),
      .en_o   (dev_en[i]),
      .base_o (dev_base[i*16 +: 16]),
      .irqa_o (dev_irq_a[i*8 +: 8]),
      .irqb_o (dev_irq_b[i*8 +: 8]),
      .dma_o  (dev_dma[i*8 +: 8]),
      .mode_o (dev_mode[i*MW +: MW]),
      .rd_o   (bank_rd[i])
    );
  end

  always_comb begin
    sel_rd = RD_NONE;
    for (int i = 0; i < NDEV; i++)
      if (dsel_q == 8'(i)) sel_rd = bank_rd[i];
  end

  always_comb begin
    if (!cfg_open)              rdata = RD_NONE;
    else if (idx_q == IX_DSEL)  rdata = dsel_q;
    else if (idx_q == IX_SRST)  rdata = 8'h00;
    else                        rdata = sel_rd;
  end
endmodule

// File: rtl/cfgp_sva.sv
module cfgp_sva
  import cfgp_pkg::*;
#(
  parameter int NDEV = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            port_sel,
  input logic [7:0]      wdata,
  input logic [7:0]      rdata,
  input logic [7:0]      idx_q,
  input logic            cfg_open,
  input logic [NDEV-1:0] dev_en
);
  a_r1_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(wr_en && !port_sel && wdata == KEY_SECOND));

  a_r2_locked_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |-> rdata == RD_NONE);

  a_r2_locked_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> $stable(dev_en));

  a_r4_exit_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && wr_en && !port_sel && wdata == KEY_EXIT) |=> !cfg_open);

  a_r5_dsel_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && wr_en && port_sel && idx_q == IX_DSEL) |=> rdata == $past(wdata));

  a_r11_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && wr_en && port_sel && idx_q == IX_SRST && wdata[0]) |=> dev_en == '0);
endmodule

bind cfgp_port cfgp_sva #(.NDEV(NDEV)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .port_sel (port_sel),
  .wdata    (wdata),
  .rdata    (rdata),
  .idx_q    (idx_q),
  .cfg_open (cfg_open),
  .dev_en   (dev_en)
);

// File: tb/cfgp_port_tb.sv
module cfgp_port_tb;
  localparam int NDEV = 9;
  localparam int NMODE = 5;

  logic                    clk;
  logic                    rst_n;
  logic                    wr_en;
  logic                    port_sel;
  logic [7:0]              wdata;
  logic [7:0]              rdata;
  logic [NDEV-1:0]         dev_en;
  logic [NDEV*16-1:0]      dev_base;
  logic [NDEV*8-1:0]       dev_irq_a;
  logic [NDEV*8-1:0]       dev_irq_b;
  logic [NDEV*8-1:0]       dev_dma;
  logic [NDEV*NMODE*8-1:0] dev_mode;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  cfgp_port #(.NDEV(NDEV), .NMODE(NMODE)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .port_sel(port_sel),
    .wdata(wdata), .rdata(rdata), .dev_en(dev_en), .dev_base(dev_base),
    .dev_irq_a(dev_irq_a), .dev_irq_b(dev_irq_b), .dev_dma(dev_dma),
    .dev_mode(dev_mode)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [383:0] act, input logic [383:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_idx(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; port_sel = 1'b0; wdata = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_dat(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; port_sel = 1'b1; wdata = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] ix, input logic [7:0] v);
    wr_idx(ix);
    wr_dat(v);
  endtask

  task automatic t_reset();
    chk("R13 en", dev_en, '0);
    chk("R13 base", dev_base, '0);
    chk("R13 mode", dev_mode, '0);
    chk("R2 locked read", rdata, 8'hFF);
  endtask

  task automatic t_locked();
    wr_dat(8'h01);
    wr_idx(8'h30);
    wr_dat(8'h01);
    chk("R2 data write ignored", dev_en, '0);
    chk("R2 locked read", rdata, 8'hFF);
  endtask

  task automatic t_badkey();
    wr_idx(8'h51); wr_idx(8'h51); wr_idx(8'h23);
    wr_idx(8'h07);
    chk("R3 repeated first byte", rdata, 8'hFF);
    wr_idx(8'h51); wr_idx(8'h00); wr_idx(8'h23);
    wr_idx(8'h07);
    chk("R3 stray byte", rdata, 8'hFF);
  endtask

  task automatic t_unlock();
    wr_idx(8'h51); wr_idx(8'h23);
    wr_idx(8'h07);
    chk("R1 unlocked select read", rdata, 8'h00);
  endtask

  task automatic t_dev4();
    wr_reg(8'h07, 8'h04);
    chk("R5 select readback", rdata, 8'h04);
    wr_reg(8'h30, 8'hFF);
    chk("R6 act readback", rdata, 8'h01);
    chk("R6 en", dev_en, 9'h010);
    wr_reg(8'h60, 8'h12); wr_reg(8'h61, 8'h34);
    chk("R7 base", dev_base[4*16 +: 16], 16'h1234);
    wr_reg(8'h70, 8'h05); wr_reg(8'h72, 8'h0C); wr_reg(8'h74, 8'h03);
    chk("R8 irq a", dev_irq_a[4*8 +: 8], 8'h05);
    chk("R8 irq b", dev_irq_b[4*8 +: 8], 8'h0C);
    chk("R8 dma", dev_dma[4*8 +: 8], 8'h03);
    chk("R8 dma readback", rdata, 8'h03);
    for (int k = 0; k < NMODE; k++) wr_reg(8'hF0 + 8'(k), 8'hA0 + 8'(k));
    for (int k = 0; k < NMODE; k++)
      chk("R9 mode", dev_mode[(4*NMODE+k)*8 +: 8], 8'hA0 + 8'(k));
  endtask

  task automatic t_isolation();
    wr_reg(8'h07, 8'h08);
    wr_reg(8'h60, 8'h56); wr_reg(8'h61, 8'h78); wr_reg(8'h30, 8'h01);
    chk("R10 dev8 base", dev_base[8*16 +: 16], 16'h5678);
    chk("R10 dev4 kept", dev_base[4*16 +: 16], 16'h1234);
    chk("R10 en", dev_en, 9'h110);
  endtask

  task automatic t_badsel();
    wr_reg(8'h07, 8'h0C);
    chk("R5 wide select readback", rdata, 8'h0C);
    wr_reg(8'h60, 8'h99);
    chk("R5 no bank read", rdata, 8'hFF);
    wr_reg(8'h30, 8'h00);
    chk("R5 no bank write base", dev_base, {16'h5678, 48'h0, 16'h1234, 64'h0});
    chk("R5 no bank write en", dev_en, 9'h110);
  endtask

  task automatic t_unmapped();
    wr_reg(8'h07, 8'h04);
    wr_reg(8'h31, 8'h55);
    chk("R12 unmapped read", rdata, 8'hFF);
    chk("R12 unmapped write", dev_en, 9'h110);
    wr_idx(8'h73);
    chk("R12 gap read", rdata, 8'hFF);
    wr_idx(8'hF5);
    chk("R12 past modes", rdata, 8'hFF);
    wr_idx(8'hF4);
    chk("R9 last mode read", rdata, 8'hA4);
  endtask

  task automatic t_softrst();
    wr_reg(8'h02, 8'hFE);
    chk("R11 bit0 clear no effect", dev_en, 9'h110);
    wr_reg(8'h02, 8'h01);
    chk("R11 en cleared", dev_en, '0);
    chk("R11 base cleared", dev_base, '0);
    chk("R11 mode cleared", dev_mode, '0);
    chk("R11 reads zero", rdata, 8'h00);
    wr_idx(8'h07);
    chk("R11 select kept", rdata, 8'h04);
  endtask

  task automatic t_exit();
    wr_idx(8'hBB);
    chk("R4 locked after exit", rdata, 8'hFF);
    wr_dat(8'h01);
    wr_idx(8'h51); wr_idx(8'h23);
    chk("R4 index kept", rdata, 8'h04);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; port_sel = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_badkey();
    t_unlock();
    t_dev4();
    t_isolation();
    t_badsel();
    t_unmapped();
    t_softrst();
    t_exit();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule